// File: doc/BRIEF.md
# Multi-cycle accumulator CPU sequencer

This block is the timing controller and datapath of a small 16-bit processor built around a single accumulator. A 4-bit step counter is decoded into sixteen one-hot timing steps. Every register transfer in the block travels over one shared 16-bit bus, and a 3-bit code picks the source that drives it. Each instruction word carries three fields: an indirect flag, a 3-bit operation code and a 12-bit address. The block fetches the word, decodes the operation into eight one-hot lines and resolves one level of indirection. It then executes the seven memory-reference operations: AND, ADD, load, store, jump, call-and-save-return, and increment-and-skip-if-zero. Each of these runs as a fixed run of steps and ends by clearing the step counter.

Operation code 7 covers register and I/O operations, which other units execute. For such a word the block raises one of two one-cycle hand-off strobes in step 3, chosen by the indirect flag, and starts the next fetch. A run flag set by reset gates all progress. A stop request from outside clears it, and the processor then holds its state. The 4096-word program memory sits inside the block. A load port writes it before the program starts.

Top module: `acc_seq_cpu`

## Requirements
- R1: After reset the step counter is 0 and only timing step 0 is active. The program counter, accumulator and carry flag E are 0, and the run flag is 1. The bus selects the program counter (code 3'b010) and so shows 0.
- R2: Fetch and decode take steps 0 to 2. In step 1 the bus selects memory (code 3'b111) and shows M[AR], which is M[PC] taken in step 0. At the end of step 1 the program counter has incremented.
- R3: When the operation code is not 7 and bit 15 is 1, step 3 loads AR with the low 12 bits of M[AR]. When bit 15 is 0, step 3 does nothing. Either way, memory-reference execution starts at step 4.
- R4: Operation codes 0 (AND), 1 (ADD) and 2 (load) read the operand in step 4 and write the accumulator in step 5. ADD also puts its carry-out in E; the other two leave E unchanged. Each instruction takes 6 cycles, or the same count when indirect.
- R5: Operation code 3 (store) writes the accumulator to M[AR] in step 4. Operation code 4 (jump) loads the program counter from AR in step 4. Each takes 5 cycles.
- R6: Operation code 5 (call) writes the return address to M[AR] in step 4. The return address is the program counter after fetch, zero-extended. Execution continues at the effective address plus 1. The instruction takes 6 cycles.
- R7: Operation code 6 increments M[AR] and writes the result back in step 6. It skips the next word when the result is 0. The instruction takes 7 cycles, and no instruction drives the step counter past 6.
- R8: Operation code 7 pulses the register hand-off strobe in step 3 when bit 15 is 0, or the I/O hand-off strobe when bit 15 is 1. It takes 4 cycles and leaves the accumulator unchanged.
- R9: A stop request clears the run flag. From then on the program counter, step counter and accumulator hold, and no memory write occurs.
- R10: The bus source codes are 001 AR, 010 PC, 011 DR, 100 AC, 101 IR, 110 TR and 111 M[AR]. AR and PC are zero-extended onto the bus, and every memory write stores the bus value at address AR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Stop request; clears the run flag |
| ld_en_i | input | 1 | Program load write enable |
| ld_addr_i | input | 12 | Program load address |
| ld_data_i | input | 16 | Program load data |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag E |
| sc_o | output | 4 | Step counter |
| t_o | output | 16 | One-hot timing steps |
| d_o | output | 8 | One-hot decoded operation |
| run_o | output | 1 | Run flag |
| bus_sel_o | output | 3 | Bus source code |
| bus_o | output | 16 | Shared bus value |
| mem_we_o | output | 1 | Write strobe from the processor |
| mem_addr_o | output | 12 | Memory address (AR) |
| mem_wdata_o | output | 16 | Memory write data |
| reg_exec_o | output | 1 | Register-operation hand-off strobe |
| io_exec_o | output | 1 | I/O-operation hand-off strobe |

## Verification
Most internal faults show at the next return of the step counter to 0, where the bench compares the cycle count of the finished instruction, the program counter and the accumulator with E. A wrong operation line, a lost indirect step or a late counter clear therefore shows within one instruction. A wrong AR, a bad bus source or a missed increment shows in the same cycle as the write, as a wrong address or value on the memory write port. A wrong skip decision shows as a wrong program counter at the next step 0, and the skipped word's store would show as an extra write.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DEF_WORD_W = 16;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_SC_W   = 4;
    localparam int DEF_OPC_W  = 3;

    // Shared-bus source codes; the numeric values are the external encoding.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_AR   = 3'd1,
        SRC_PC   = 3'd2,
        SRC_DR   = 3'd3,
        SRC_AC   = 3'd4,
        SRC_IR   = 3'd5,
        SRC_TR   = 3'd6,
        SRC_MEM  = 3'd7
    } bus_src_e;

    typedef enum logic [1:0] {
        ALU_AND  = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_PASS = 2'd2
    } alu_op_e;

    // Operation line indices of the decoded operation code.
    localparam int OPL_AND = 0;
    localparam int OPL_ADD = 1;
    localparam int OPL_LDA = 2;
    localparam int OPL_STA = 3;
    localparam int OPL_BUN = 4;
    localparam int OPL_BSA = 5;
    localparam int OPL_ISZ = 6;
    localparam int OPL_EXT = 7;

    // One step's worth of control strobes.
    typedef struct packed {
        bus_src_e src;
        logic     ar_ld;
        logic     ar_inc;
        logic     pc_ld;
        logic     pc_inc;
        logic     ir_ld;
        logic     dr_ld;
        logic     dr_inc;
        logic     ac_ld;
        alu_op_e  alu;
        logic     e_ld;
        logic     i_ld;
        logic     mem_we;
        logic     sc_clr;
    } step_ctrl_t;

    function automatic step_ctrl_t ctrl_idle();
        step_ctrl_t c;
        c        = '0;
        c.src    = SRC_NONE;
        c.alu    = ALU_PASS;
        return c;
    endfunction

endpackage

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
    parameter int SC_W = 4,
    localparam int STEPS = 1 << SC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             clr,
    output logic [SC_W-1:0]  sc,
    output logic [STEPS-1:0] t
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sc <= '0;
        end else if (adv) begin
            if (clr) sc <= '0;
            else     sc <= sc + 1'b1;
        end
    end

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        assign t[g] = (sc == SC_W'(g));
    end

    // R1: exactly one timing step is active in every cycle
    assert_one_step_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(t) == 1);

    // R2: an advancing, uncleared counter moves to the next step
    assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
        adv && !clr |=> sc == $past(sc) + 1'b1);

endmodule

// File: rtl/acc_op_decoder.sv
module acc_op_decoder #(
    parameter int OPC_W = 3,
    localparam int NOPS = 1 << OPC_W
) (
    input  logic [OPC_W-1:0] opc,
    output logic [NOPS-1:0]  d
);

    for (genvar g = 0; g < NOPS; g++) begin : g_line
        assign d[g] = (opc == OPC_W'(g));
    end

endmodule

// File: rtl/acc_bus_mux.sv
module acc_bus_mux
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  bus_src_e     src,
    input  logic [W-1:0] ar_w,
    input  logic [W-1:0] pc_w,
    input  logic [W-1:0] dr_w,
    input  logic [W-1:0] ac_w,
    input  logic [W-1:0] ir_w,
    input  logic [W-1:0] tr_w,
    input  logic [W-1:0] mem_w,
    output logic [W-1:0] bus
);

    always_comb begin
        unique case (src)
            SRC_AR:   bus = ar_w;
            SRC_PC:   bus = pc_w;
            SRC_DR:   bus = dr_w;
            SRC_AC:   bus = ac_w;
            SRC_IR:   bus = ir_w;
            SRC_TR:   bus = tr_w;
            SRC_MEM:  bus = mem_w;
            default:  bus = '0;
        endcase
    end

endmodule

// File: rtl/acc_word_mem.sv
module acc_word_mem #(
    parameter int AW = 12,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Read data is available in the cycle the address is presented.
    assign rdata = cells[raddr];

endmodule

// File: rtl/acc_seq_cpu.sv
module acc_seq_cpu
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int SC_W   = DEF_SC_W,
    parameter int OPC_W  = DEF_OPC_W,
    localparam int STEPS = 1 << SC_W,
    localparam int NOPS  = 1 << OPC_W,
    localparam int PAD_W = WORD_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_i,
    input  logic              ld_en_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [WORD_W-1:0] ld_data_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] ac_o,
    output logic              e_o,
    output logic [SC_W-1:0]   sc_o,
    output logic [STEPS-1:0]  t_o,
    output logic [NOPS-1:0]   d_o,
    output logic              run_o,
    output logic [2:0]        bus_sel_o,
    output logic [WORD_W-1:0] bus_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              reg_exec_o,
    output logic              io_exec_o
);

    // ---------------- architectural state ----------------
    logic [ADDR_W-1:0] ar_q, pc_q;
    logic [WORD_W-1:0] dr_q, ac_q, ir_q;
    logic              e_q, i_q, run_q;

    logic [SC_W-1:0]   sc;
    logic [STEPS-1:0]  t;
    logic [NOPS-1:0]   d;
    logic [WORD_W-1:0] bus, mem_rdata;
    step_ctrl_t        ctl;

    // ---------------- sequencing and decode ----------------
    acc_seq_timer #(.SC_W(SC_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .adv (run_q),
        .clr (ctl.sc_clr),
        .sc  (sc),
        .t   (t)
    );

    acc_op_decoder #(.OPC_W(OPC_W)) u_dec (
        .opc (ir_q[WORD_W-2 -: OPC_W]),
        .d   (d)
    );

    // ---------------- shared bus ----------------
    acc_bus_mux #(.W(WORD_W)) u_bus (
        .src   (ctl.src),
        .ar_w  ({{PAD_W{1'b0}}, ar_q}),
        .pc_w  ({{PAD_W{1'b0}}, pc_q}),
        .dr_w  (dr_q),
        .ac_w  (ac_q),
        .ir_w  (ir_q),
        .tr_w  ({WORD_W{1'b0}}),   // no step of this block loads TR
        .mem_w (mem_rdata),
        .bus   (bus)
    );

    // ---------------- memory with program-load port ----------------
    logic              cpu_we;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    assign cpu_we    = ctl.mem_we && run_q;
    assign mem_we    = ld_en_i || cpu_we;
    assign mem_waddr = ld_en_i ? ld_addr_i : ar_q;
    assign mem_wdata = ld_en_i ? ld_data_i : bus;

    acc_word_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ar_q),
        .rdata (mem_rdata)
    );

    // ---------------- step control ----------------
    always_comb begin
        ctl = ctrl_idle();
        unique case (1'b1)
            t[0]: begin
                ctl.src   = SRC_PC;
                ctl.ar_ld = 1'b1;
            end
            t[1]: begin
                ctl.src    = SRC_MEM;
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            t[2]: begin
                ctl.src   = SRC_IR;
                ctl.ar_ld = 1'b1;
                ctl.i_ld  = 1'b1;
            end
            t[3]: begin
                if (d[OPL_EXT]) begin
                    ctl.sc_clr = 1'b1;
                end else if (i_q) begin
                    ctl.src   = SRC_MEM;
                    ctl.ar_ld = 1'b1;
                end
            end
            t[4]: begin
                if (d[OPL_AND] || d[OPL_ADD] || d[OPL_LDA] || d[OPL_ISZ]) begin
                    ctl.src   = SRC_MEM;
                    ctl.dr_ld = 1'b1;
                end else if (d[OPL_STA]) begin
                    ctl.src    = SRC_AC;
                    ctl.mem_we = 1'b1;
                    ctl.sc_clr = 1'b1;
                end else if (d[OPL_BUN]) begin
                    ctl.src    = SRC_AR;
                    ctl.pc_ld  = 1'b1;
                    ctl.sc_clr = 1'b1;
                end else if (d[OPL_BSA]) begin
                    ctl.src    = SRC_PC;
                    ctl.mem_we = 1'b1;
                    ctl.ar_inc = 1'b1;
                end else begin
                    ctl.sc_clr = 1'b1;
                end
            end
            t[5]: begin
                if (d[OPL_AND]) begin
                    ctl.ac_ld  = 1'b1;
                    ctl.alu    = ALU_AND;
                    ctl.sc_clr = 1'b1;
                end else if (d[OPL_ADD]) begin
                    ctl.ac_ld  = 1'b1;
                    ctl.alu    = ALU_ADD;
                    ctl.e_ld   = 1'b1;
                    ctl.sc_clr = 1'b1;
                end else if (d[OPL_LDA]) begin
                    ctl.ac_ld  = 1'b1;
                    ctl.alu    = ALU_PASS;
                    ctl.sc_clr = 1'b1;
                end else if (d[OPL_BSA]) begin
                    ctl.src    = SRC_AR;
                    ctl.pc_ld  = 1'b1;
                    ctl.sc_clr = 1'b1;
                end else if (d[OPL_ISZ]) begin
                    ctl.dr_inc = 1'b1;
                end else begin
                    ctl.sc_clr = 1'b1;
                end
            end
            t[6]: begin
                ctl.sc_clr = 1'b1;
                if (d[OPL_ISZ]) begin
                    ctl.src    = SRC_DR;
                    ctl.mem_we = 1'b1;
                    ctl.pc_inc = (dr_q == '0);
                end
            end
            default: ctl.sc_clr = 1'b1;
        endcase
    end

    // ---------------- ALU ----------------
    logic [WORD_W-1:0] alu_res;
    logic              alu_cout;

    always_comb begin
        alu_cout = e_q;
        unique case (ctl.alu)
            ALU_AND: alu_res = ac_q & dr_q;
            ALU_ADD: {alu_cout, alu_res} = {1'b0, ac_q} + {1'b0, dr_q};
            default: alu_res = dr_q;
        endcase
    end

    // ---------------- register updates ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b1;
        end else if (halt_i) begin
            run_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
            pc_q <= '0;
            dr_q <= '0;
            ac_q <= '0;
            ir_q <= '0;
            e_q  <= 1'b0;
            i_q  <= 1'b0;
        end else if (run_q) begin
            if (ctl.ar_ld)       ar_q <= bus[ADDR_W-1:0];
            else if (ctl.ar_inc) ar_q <= ar_q + 1'b1;

            if (ctl.pc_ld)       pc_q <= bus[ADDR_W-1:0];
            else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;

            if (ctl.ir_ld)       ir_q <= bus;

            if (ctl.dr_ld)       dr_q <= bus;
            else if (ctl.dr_inc) dr_q <= dr_q + 1'b1;

            if (ctl.ac_ld)       ac_q <= alu_res;
            if (ctl.e_ld)        e_q  <= alu_cout;
            if (ctl.i_ld)        i_q  <= ir_q[WORD_W-1];
        end
    end

    // ---------------- outputs ----------------
    assign pc_o        = pc_q;
    assign ac_o        = ac_q;
    assign e_o         = e_q;
    assign sc_o        = sc;
    assign t_o         = t;
    assign d_o         = d;
    assign run_o       = run_q;
    assign bus_sel_o   = ctl.src;
    assign bus_o       = bus;
    assign mem_we_o    = cpu_we;
    assign mem_addr_o  = ar_q;
    assign mem_wdata_o = bus;
    assign reg_exec_o  = run_q && t[3] && d[OPL_EXT] && !i_q;
    assign io_exec_o   = run_q && t[3] && d[OPL_EXT] && i_q;

    // ---------------- assertions ----------------
    // R2: the fetch step leaves the program counter one higher
    assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (rst)
        run_q && t[1] |=> pc_q == $past(pc_q) + 1'b1);

    // R3: indirect resolution loads AR from the word it pointed at
    assert_indirect_ar_R3: assert property (@(posedge clk) disable iff (rst)
        run_q && t[3] && !d[OPL_EXT] && i_q |=> ar_q == $past(mem_rdata[ADDR_W-1:0]));

    // R4: ADD leaves the 17-bit sum of the previous AC and DR in E and AC
    assert_add_carry_R4: assert property (@(posedge clk) disable iff (rst)
        run_q && t[5] && d[OPL_ADD] |=>
        {e_q, ac_q} == {1'b0, $past(ac_q)} + {1'b0, $past(dr_q)});

    // R5: processor memory writes happen only in steps 4 and 6
    assert_write_step_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_we |-> (t[4] || t[6]));

    // R7: the step counter never passes step 6
    assert_sc_bound_R7: assert property (@(posedge clk) disable iff (rst)
        sc <= SC_W'(6));

    // R8: a hand-off strobe is followed by a fresh fetch
    assert_handoff_refetch_R8: assert property (@(posedge clk) disable iff (rst)
        reg_exec_o || io_exec_o |=> sc == '0);

    // R9: with the run flag clear, state holds
    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> $stable(pc_q) && $stable(sc) && $stable(ac_q) && !cpu_we);

endmodule

// File: tb/tb_acc_seq_cpu.sv
`timescale 1ns/1ps
module tb_acc_seq_cpu;

    logic        clk = 1'b0;
    logic        rst;
    logic        halt_i;
    logic        ld_en_i;
    logic [11:0] ld_addr_i;
    logic [15:0] ld_data_i;
    logic [11:0] pc_o;
    logic [15:0] ac_o;
    logic        e_o;
    logic [3:0]  sc_o;
    logic [15:0] t_o;
    logic [7:0]  d_o;
    logic        run_o;
    logic [2:0]  bus_sel_o;
    logic [15:0] bus_o;
    logic        mem_we_o;
    logic [11:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic        reg_exec_o;
    logic        io_exec_o;

    always #2.5 clk = ~clk;

    acc_seq_cpu dut (
        .clk(clk), .rst(rst), .halt_i(halt_i),
        .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
        .pc_o(pc_o), .ac_o(ac_o), .e_o(e_o), .sc_o(sc_o), .t_o(t_o), .d_o(d_o),
        .run_o(run_o), .bus_sel_o(bus_sel_o), .bus_o(bus_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .reg_exec_o(reg_exec_o), .io_exec_o(io_exec_o)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [11:0] pc;
        logic [15:0] ac;
        logic        e;
        int          len;
        string       req;
    } done_item_t;

    typedef struct {
        logic [11:0] addr;
        logic [15:0] data;
        string       req;
    } wr_item_t;

    done_item_t done_q[$];
    wr_item_t   wr_q[$];

    task automatic expect_done(input logic [11:0] pc, input logic [15:0] ac,
                               input logic e, input int len, input string req);
        done_item_t it;
        it.pc = pc; it.ac = ac; it.e = e; it.len = len; it.req = req;
        done_q.push_back(it);
    endtask

    task automatic expect_write(input logic [11:0] a, input logic [15:0] v,
                                input string req);
        wr_item_t it;
        it.addr = a; it.data = v; it.req = req;
        wr_q.push_back(it);
    endtask

    task automatic load_word(input logic [11:0] a, input logic [15:0] v);
        @(negedge clk);
        ld_en_i   = 1'b1;
        ld_addr_i = a;
        ld_data_i = v;
        @(negedge clk);
        ld_en_i   = 1'b0;
    endtask

    int reg_pulses = 0;
    int io_pulses  = 0;
    int step_cnt   = 1;

    // Monitor: samples 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst && run_o) begin
            if (mem_we_o) begin
                if (wr_q.size() == 0) begin
                    check(1'b0, "R10 unexpected memory write addr", 32'(mem_addr_o), 32'hFFFF);
                end else begin
                    wr_item_t w;
                    w = wr_q.pop_front();
                    check(mem_addr_o == w.addr, {w.req, " write address"},
                          32'(mem_addr_o), 32'(w.addr));
                    check(mem_wdata_o == w.data, {w.req, " write data"},
                          32'(mem_wdata_o), 32'(w.data));
                end
            end
            if (reg_exec_o) reg_pulses++;
            if (io_exec_o)  io_pulses++;
            if (sc_o == 4'd0) begin
                if (done_q.size() != 0) begin
                    done_item_t x;
                    x = done_q.pop_front();
                    check(step_cnt == x.len, {x.req, " cycle count"},
                          32'(step_cnt), 32'(x.len));
                    check(pc_o == x.pc, {x.req, " program counter"},
                          32'(pc_o), 32'(x.pc));
                    check(ac_o == x.ac, {x.req, " accumulator"},
                          32'(ac_o), 32'(x.ac));
                    check(e_o == x.e, {x.req, " carry E"},
                          32'(e_o), 32'(x.e));
                end
                step_cnt = 1;
            end else begin
                step_cnt++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(done_q.size()), 32'd0);
        report();
    end

    // Driver
    initial begin
        logic [11:0] pc_hold;
        logic [3:0]  sc_hold;
        logic [15:0] ac_hold;
        rst = 1'b1; halt_i = 1'b0;
        ld_en_i = 1'b0; ld_addr_i = '0; ld_data_i = '0;

        // Program: opcode in bits 14..12, indirect flag in bit 15.
        load_word(12'h000, 16'h2100);   // load   M[100]
        load_word(12'h001, 16'h0101);   // and    M[101]
        load_word(12'h002, 16'h1102);   // add    M[102]
        load_word(12'h003, 16'h3103);   // store  M[103]
        load_word(12'h004, 16'h9104);   // add    indirect via M[104]
        load_word(12'h005, 16'h6106);   // incr-skip M[106] (skips)
        load_word(12'h006, 16'h31FF);   // store  M[1FF] (must be skipped)
        load_word(12'h007, 16'h6107);   // incr-skip M[107] (no skip)
        load_word(12'h008, 16'h5110);   // call   110
        load_word(12'h111, 16'hC110);   // jump   indirect via M[110]
        load_word(12'h009, 16'h3108);   // store  M[108]
        load_word(12'h00A, 16'h7800);   // register-type word
        load_word(12'h00B, 16'hF400);   // I/O-type word
        load_word(12'h00C, 16'h400C);   // jump to self
        load_word(12'h100, 16'h1234);
        load_word(12'h101, 16'h0FF0);
        load_word(12'h102, 16'hFFF0);
        load_word(12'h104, 16'h0105);
        load_word(12'h105, 16'h0001);
        load_word(12'h106, 16'hFFFF);
        load_word(12'h107, 16'h0005);

        expect_done(12'h001, 16'h1234, 1'b0, 6, "R4 load");
        expect_done(12'h002, 16'h0230, 1'b0, 6, "R4 and");
        expect_done(12'h003, 16'h0220, 1'b1, 6, "R4 add carry");
        expect_done(12'h004, 16'h0220, 1'b1, 5, "R5 store");
        expect_done(12'h005, 16'h0221, 1'b0, 6, "R3 indirect add");
        expect_done(12'h007, 16'h0221, 1'b0, 7, "R7 skip taken");
        expect_done(12'h008, 16'h0221, 1'b0, 7, "R7 no skip");
        expect_done(12'h111, 16'h0221, 1'b0, 6, "R6 call");
        expect_done(12'h009, 16'h0221, 1'b0, 5, "R3 indirect jump");
        expect_done(12'h00A, 16'h0221, 1'b0, 5, "R5 store after return");
        expect_done(12'h00B, 16'h0221, 1'b0, 4, "R8 register hand-off");
        expect_done(12'h00C, 16'h0221, 1'b0, 4, "R8 io hand-off");
        expect_done(12'h00C, 16'h0221, 1'b0, 5, "R5 jump");
        expect_done(12'h00C, 16'h0221, 1'b0, 5, "R5 jump repeat");

        expect_write(12'h103, 16'h0220, "R5 store");
        expect_write(12'h106, 16'h0000, "R7 skip taken");
        expect_write(12'h107, 16'h0006, "R7 no skip");
        expect_write(12'h110, 16'h0009, "R6 return address");
        expect_write(12'h108, 16'h0221, "R10 store after return");

        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check(sc_o == 4'd0,        "R1 step counter",  32'(sc_o), 32'd0);
        check(t_o == 16'h0001,     "R1 timing steps",  32'(t_o), 32'h1);
        check(pc_o == 12'h000,     "R1 program counter", 32'(pc_o), 32'd0);
        check(ac_o == 16'h0000,    "R1 accumulator",   32'(ac_o), 32'd0);
        check(e_o == 1'b0,         "R1 carry E",       32'(e_o), 32'd0);
        check(run_o == 1'b1,       "R1 run flag",      32'(run_o), 32'd1);
        check(bus_sel_o == 3'b010, "R1 bus select",    32'(bus_sel_o), 32'h2);
        check(bus_o == 16'h0000,   "R1 bus value",     32'(bus_o), 32'd0);

        @(negedge clk);
        check(bus_sel_o == 3'b111, "R2 fetch bus select", 32'(bus_sel_o), 32'h7);
        check(bus_o == 16'h2100,   "R2 fetch bus value",  32'(bus_o), 32'h2100);
        @(negedge clk);
        check(pc_o == 12'h001,     "R2 pc after fetch",   32'(pc_o), 32'h1);

        while (done_q.size() != 0 || wr_q.size() != 0) @(negedge clk);

        check(reg_pulses == 1, "R8 register strobe count", 32'(reg_pulses), 32'd1);
        check(io_pulses == 1,  "R8 io strobe count",       32'(io_pulses), 32'd1);

        halt_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0;
        check(run_o == 1'b0, "R9 run flag cleared", 32'(run_o), 32'd0);
        pc_hold = pc_o; sc_hold = sc_o; ac_hold = ac_o;
        repeat (12) @(negedge clk);
        check(pc_o == pc_hold, "R9 pc held",  32'(pc_o), 32'(pc_hold));
        check(sc_o == sc_hold, "R9 sc held",  32'(sc_o), 32'(sc_hold));
        check(ac_o == ac_hold, "R9 ac held",  32'(ac_o), 32'(ac_hold));
        check(mem_we_o == 1'b0, "R9 no write", 32'(mem_we_o), 32'd0);

        report();
    end

endmodule